// File: doc/BRIEF.md
# Indexed Clock-Register Port with Interrupt Status

This block is the software-facing register file of a real-time clock. A processor reaches 128 byte locations through two addresses: the even address holds a pointer, and the odd address reads or writes the location that the pointer selects. Four locations carry control and status. Two are control words for the mode and the interrupt enables. One is a flag word that clears when it is read. The last is a fixed validity byte. Three other locations hold alarm bytes for seconds, minutes and hours. All remaining locations are plain byte storage.

The time-keeping counters and the rate divider sit outside this block. They signal the block through single-cycle pulses: a periodic tick, the start of an update, and the end of an update. They also supply the current seconds, minutes and hours in the same encoding the software uses. From these inputs the block keeps the sticky event flags, compares the alarm, tracks the update-in-progress bit, and drives a level interrupt that stays high until software reads the flag word.

Top module: `rtc_regport`

## Requirements
- R1: After reset, control word A (index 10) reads 0x26, control word B (index 11) reads 0x02, flag word C (index 12) reads 0x00, word D (index 13) reads 0x80, and `irq` is low.
- R2: A write to the even address loads the pointer from write-data bits 6:0 and ignores bit 7. A read from the even address returns 0xFF.
- R3: A write to the odd address stores the byte at the pointed location. While a read strobe is high at the odd address, `bus_rdata` shows the pointed location in that same cycle.
- R4: Writes to index 12 and to index 13 change nothing that a read can observe.
- R5: Bit 7 of control word A is the update-in-progress bit. A write keeps its current value and replaces bits 6:0.
- R6: An update-start pulse sets bit 7 of A one cycle later, but only when bit 7 (SET) of B is 0. An update-end pulse clears it.
- R7: A write to B with bit 7 high clears bit 7 of A, and B stores bit 4 (update-end enable) as 0.
- R8: A periodic pulse sets C bit 6 and an update-end pulse sets C bit 4, whatever the enables. These flags stay set until C is read.
- R9: With B bit 6 (periodic enable), B bit 5 (alarm enable) or B bit 4 (update-end enable) set, the matching event sets C bit 7 and drives `irq` high from the next cycle on. With the enable clear, `irq` stays low.
- R10: The alarm bytes sit at index 1 (seconds), 3 (minutes) and 5 (hours). A byte matches when its bits 7:6 are both 1 or when it equals the current field. On an update-end pulse with all three bytes matching, C bit 5 is set.
- R11: A read of index 12 at the odd address returns the flags, then clears all of C and lowers `irq` at the next edge. An event pulse in the same cycle as that read is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 selects the pointer, 1 selects the pointed byte |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while the strobe is high |
| evt_periodic | input | 1 | Periodic tick pulse |
| evt_uip_start | input | 1 | Update-start pulse |
| evt_update | input | 1 | Update-end pulse |
| cur_sec | input | 8 | Current seconds, in register encoding |
| cur_min | input | 8 | Current minutes, in register encoding |
| cur_hour | input | 8 | Current hours, in register encoding |
| irq | output | 1 | Level interrupt request |
| ctrl_a | output | 8 | Current value of control word A |
| ctrl_b | output | 8 | Current value of control word B |

## Verification
Read data is combinational, so a read result is due in the cycle where the strobe is high. The scoreboard monitor takes it at the falling edge inside that strobe window. Writes, event pulses and the clear-on-read register at the next rising edge. Every read or `irq` check therefore follows the task that caused the change, and is taken at least one full edge later. The `irq` line is sampled at the falling edge after the edge that registered the pulse or the read of C. This places it one cycle after the stimulus, as R9 and R11 state.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
    localparam int PTR_W    = 7;
    localparam int BYTE_W   = 8;
    localparam int NUM_LOC  = 1 << PTR_W;
    localparam int NUM_ALM  = 3;

    localparam logic [PTR_W-1:0] IDX_A = 7'd10;
    localparam logic [PTR_W-1:0] IDX_B = 7'd11;
    localparam logic [PTR_W-1:0] IDX_C = 7'd12;
    localparam logic [PTR_W-1:0] IDX_D = 7'd13;

    // alarm byte positions, ordered seconds, minutes, hours
    localparam logic [PTR_W-1:0] IDX_ALM_SEC  = 7'd1;
    localparam logic [PTR_W-1:0] IDX_ALM_MIN  = 7'd3;
    localparam logic [PTR_W-1:0] IDX_ALM_HOUR = 7'd5;

    // control word B fields
    localparam int B_SET  = 7;
    localparam int B_PIE  = 6;
    localparam int B_AIE  = 5;
    localparam int B_UIE  = 4;
    localparam int B_SQWE = 3;

    // control word A
    localparam int A_UIP = 7;

    // flag word C
    localparam int C_IRQ = 7;
    localparam int C_PF  = 6;
    localparam int C_AF  = 5;
    localparam int C_UF  = 4;

    localparam logic [BYTE_W-1:0] RST_A = 8'h26;
    localparam logic [BYTE_W-1:0] RST_B = 8'h02;
    localparam logic [BYTE_W-1:0] VAL_D = 8'h80;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] b;
    } ctrl_regs_t;

    typedef struct packed {
        logic irqf;
        logic pf;
        logic af;
        logic uf;
    } flags_t;
endpackage

// File: rtl/rtc_alarm_field.sv
module rtc_alarm_field #(
    parameter int W = 8
) (
    input  logic [W-1:0] alarm_byte,
    input  logic [W-1:0] now_byte,
    output logic         hit
);
    logic any_value;

    always_comb begin
        any_value = &alarm_byte[W-1:W-2];
        hit       = any_value || (alarm_byte == now_byte);
    end
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store
    import rtc_regport_pkg::*;
#(
    parameter int DEPTH = NUM_LOC,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [AW-1:0]             ptr,
    input  logic [DW-1:0]             wdata,
    output logic [DW-1:0]             rdata,
    output logic [NUM_ALM-1:0][DW-1:0] alarm_bytes
);
    localparam logic [NUM_ALM-1:0][AW-1:0] TAP_IDX = {IDX_ALM_HOUR, IDX_ALM_MIN, IDX_ALM_SEC};

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[ptr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                mem_q[i] <= '0;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[ptr];

    for (genvar g = 0; g < NUM_ALM; g++) begin : g_tap
        assign alarm_bytes[g] = mem_q[TAP_IDX[g]];
    end
endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags
    import rtc_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              evt_periodic,
    input  logic              evt_update,
    input  logic              alarm_hit,
    input  logic              en_periodic,
    input  logic              en_alarm,
    input  logic              en_update,
    output logic [BYTE_W-1:0] flag_byte,
    output logic              irq
);
    flags_t flg_d, flg_q;
    logic   alarm_evt;
    logic   req_any;

    always_comb begin
        alarm_evt = evt_update && alarm_hit;
        req_any   = (evt_periodic && en_periodic) ||
                    (alarm_evt    && en_alarm)    ||
                    (evt_update   && en_update);
        // the clear acts first so an event in the same cycle survives
        flg_d      = clr ? '0 : flg_q;
        flg_d.pf   = flg_d.pf   | evt_periodic;
        flg_d.uf   = flg_d.uf   | evt_update;
        flg_d.af   = flg_d.af   | alarm_evt;
        flg_d.irqf = flg_d.irqf | req_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= '0;
        end else begin
            flg_q <= flg_d;
        end
    end

    always_comb begin
        flag_byte        = '0;
        flag_byte[C_IRQ] = flg_q.irqf;
        flag_byte[C_PF]  = flg_q.pf;
        flag_byte[C_AF]  = flg_q.af;
        flag_byte[C_UF]  = flg_q.uf;
    end

    assign irq = flg_q.irqf;
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
    import rtc_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              evt_periodic,
    input  logic              evt_uip_start,
    input  logic              evt_update,
    input  logic [BYTE_W-1:0] cur_sec,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_hour,
    output logic              irq,
    output logic [BYTE_W-1:0] ctrl_a,
    output logic [BYTE_W-1:0] ctrl_b
);
    ctrl_regs_t regs_d, regs_q;

    logic                       ptr_wr, data_wr, data_rd;
    logic                       sel_a, sel_b, sel_c, sel_d;
    logic                       store_we;
    logic [BYTE_W-1:0]          store_rdata;
    logic [BYTE_W-1:0]          flag_byte;
    logic [NUM_ALM-1:0][BYTE_W-1:0] alarm_bytes;
    logic [NUM_ALM-1:0][BYTE_W-1:0] now_bytes;
    logic [NUM_ALM-1:0]         field_hit;
    logic                       alarm_hit;
    logic                       rd_clear;
    logic [PTR_W-1:0]           cur_ptr;

    // ---------------- bus decode ----------------
    always_comb begin
        ptr_wr   = bus_wr && !bus_addr;
        data_wr  = bus_wr &&  bus_addr;
        data_rd  = bus_rd &&  bus_addr;
        sel_a    = (regs_q.ptr == IDX_A);
        sel_b    = (regs_q.ptr == IDX_B);
        sel_c    = (regs_q.ptr == IDX_C);
        sel_d    = (regs_q.ptr == IDX_D);
        store_we = data_wr && !(sel_a || sel_b || sel_c || sel_d);
        rd_clear = data_rd && sel_c;
    end

    // ---------------- next state ----------------
    always_comb begin
        regs_d = regs_q;

        if (ptr_wr) begin
            regs_d.ptr = bus_wdata[PTR_W-1:0];
        end

        if (data_wr && sel_a) begin
            regs_d.a = {regs_q.a[A_UIP], bus_wdata[A_UIP-1:0]};
        end

        if (evt_uip_start && !regs_q.b[B_SET]) begin
            regs_d.a[A_UIP] = 1'b1;
        end
        if (evt_update) begin
            regs_d.a[A_UIP] = 1'b0;
        end

        if (data_wr && sel_b) begin
            regs_d.b = bus_wdata;
            if (bus_wdata[B_SET]) begin
                regs_d.b[B_UIE] = 1'b0;
                regs_d.a[A_UIP] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.ptr <= '0;
            regs_q.a   <= RST_A;
            regs_q.b   <= RST_B;
        end else begin
            regs_q <= regs_d;
        end
    end

    // ---------------- storage ----------------
    rtc_byte_store #(
        .DEPTH (NUM_LOC),
        .AW    (PTR_W),
        .DW    (BYTE_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (store_we),
        .ptr         (regs_q.ptr),
        .wdata       (bus_wdata),
        .rdata       (store_rdata),
        .alarm_bytes (alarm_bytes)
    );

    // ---------------- alarm compare ----------------
    assign now_bytes = {cur_hour, cur_min, cur_sec};

    for (genvar g = 0; g < NUM_ALM; g++) begin : g_alarm
        rtc_alarm_field #(.W(BYTE_W)) u_field (
            .alarm_byte (alarm_bytes[g]),
            .now_byte   (now_bytes[g]),
            .hit        (field_hit[g])
        );
    end

    assign alarm_hit = &field_hit;

    // ---------------- flags and interrupt ----------------
    rtc_status_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (rd_clear),
        .evt_periodic (evt_periodic),
        .evt_update   (evt_update),
        .alarm_hit    (alarm_hit),
        .en_periodic  (regs_q.b[B_PIE]),
        .en_alarm     (regs_q.b[B_AIE]),
        .en_update    (regs_q.b[B_UIE]),
        .flag_byte    (flag_byte),
        .irq          (irq)
    );

    // ---------------- read mux ----------------
    always_comb begin
        if (!bus_addr) begin
            bus_rdata = '1;
        end else if (sel_a) begin
            bus_rdata = regs_q.a;
        end else if (sel_b) begin
            bus_rdata = regs_q.b;
        end else if (sel_c) begin
            bus_rdata = flag_byte;
        end else if (sel_d) begin
            bus_rdata = VAL_D;
        end else begin
            bus_rdata = store_rdata;
        end
    end

    assign cur_ptr = regs_q.ptr;
    assign ctrl_a  = regs_q.a;
    assign ctrl_b  = regs_q.b;
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk
    import rtc_regport_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              evt_periodic,
    input logic              evt_uip_start,
    input logic              evt_update,
    input logic              irq,
    input logic [BYTE_W-1:0] ctrl_a,
    input logic [BYTE_W-1:0] ctrl_b,
    input logic [PTR_W-1:0]  cur_ptr
);
    // R2
    ptr_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_addr) |-> (bus_rdata == 8'hFF));

    // R5
    uip_write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && cur_ptr == IDX_A && !evt_uip_start && !evt_update)
        |=> (ctrl_a[A_UIP] == $past(ctrl_a[A_UIP])));

    // R7
    set_mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && cur_ptr == IDX_B && bus_wdata[B_SET])
        |=> (!ctrl_b[B_UIE] && !ctrl_a[A_UIP]));

    // R9
    periodic_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_periodic && ctrl_b[B_PIE]) |=> irq);

    // R11
    read_clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr && cur_ptr == IDX_C && !evt_periodic && !evt_update)
        |=> !irq);

    // R4
    flag_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && cur_ptr == IDX_C && !evt_periodic && !evt_update && !irq)
        |=> !irq);
endmodule

bind rtc_regport rtc_regport_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .evt_periodic  (evt_periodic),
    .evt_uip_start (evt_uip_start),
    .evt_update    (evt_update),
    .irq           (irq),
    .ctrl_a        (ctrl_a),
    .ctrl_b        (ctrl_b),
    .cur_ptr       (cur_ptr)
);

// File: tb/rtc_regport_tb.sv
module rtc_regport_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       evt_periodic = 1'b0;
    logic       evt_uip_start = 1'b0;
    logic       evt_update = 1'b0;
    logic [7:0] cur_sec = 8'h12;
    logic [7:0] cur_min = 8'h34;
    logic [7:0] cur_hour = 8'h12;
    logic       irq;
    logic [7:0] ctrl_a, ctrl_b;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #5 clk = ~clk;

    rtc_regport u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_periodic(evt_periodic), .evt_uip_start(evt_uip_start),
        .evt_update(evt_update), .cur_sec(cur_sec), .cur_min(cur_min),
        .cur_hour(cur_hour), .irq(irq), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
    );

    // monitor: read data is due inside the strobe cycle
    always @(negedge clk) begin
        if (bus_rd) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read with no expected item, actual %02h", bus_rdata);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: read actual %02h expected %02h", it.req, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, input logic [7:0] exp, input string req, input logic with_evt);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1; evt_periodic = with_evt;
        sb_q.push_back('{exp, req});
        @(posedge clk); #1;
        bus_rd = 1'b0; evt_periodic = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
        wr(1'b0, idx);
        wr(1'b1, d);
    endtask

    task automatic rreg(input logic [7:0] idx, input logic [7:0] exp, input string req);
        wr(1'b0, idx);
        rd(1'b1, exp, req, 1'b0);
    endtask

    // which: 0 periodic, 1 update start, 2 update end
    task automatic pulse(input int which);
        @(posedge clk); #1;
        case (which)
            0: evt_periodic = 1'b1;
            1: evt_uip_start = 1'b1;
            default: evt_update = 1'b1;
        endcase
        @(posedge clk); #1;
        evt_periodic = 1'b0; evt_uip_start = 1'b0; evt_update = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string req);
        @(negedge clk);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s: irq actual %0b expected %0b", req, irq, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk_irq(1'b0, "R1");
        rreg(8'd10, 8'h26, "R1");
        rreg(8'd11, 8'h02, "R1");
        rreg(8'd12, 8'h00, "R1");
        rreg(8'd13, 8'h80, "R1");

        // R2 even-address read and pointer bit 7 ignored
        rd(1'b0, 8'hFF, "R2", 1'b0);
        wr(1'b0, 8'h8A);
        rd(1'b1, 8'h26, "R2", 1'b0);

        // R3 general storage
        wreg(8'h20, 8'h5A);
        rreg(8'h20, 8'h5A, "R3");
        wreg(8'h7F, 8'hC3);
        rreg(8'h7F, 8'hC3, "R3");
        rreg(8'h20, 8'h5A, "R3");

        // R4 flag and validity words ignore writes
        wreg(8'd12, 8'hFF);
        rreg(8'd12, 8'h00, "R4");
        chk_irq(1'b0, "R4");
        wreg(8'd13, 8'h00);
        rreg(8'd13, 8'h80, "R4");

        // R5 update-in-progress bit is read-only
        wreg(8'd10, 8'hA5);
        rreg(8'd10, 8'h25, "R5");
        pulse(1);
        rreg(8'd10, 8'hA5, "R6");
        wreg(8'd10, 8'h26);
        rreg(8'd10, 8'hA6, "R5");

        // R6 update end clears UIP, R8 sets update flag
        pulse(2);
        rreg(8'd10, 8'h26, "R6");
        chk_irq(1'b0, "R9");
        rreg(8'd12, 8'h10, "R8");
        rreg(8'd12, 8'h00, "R11");

        // R6/R7 set mode
        wreg(8'd11, 8'h92);
        rreg(8'd11, 8'h82, "R7");
        pulse(1);
        rreg(8'd10, 8'h26, "R6");
        wreg(8'd11, 8'h02);
        pulse(1);
        rreg(8'd10, 8'hA6, "R6");
        wreg(8'd11, 8'h80);
        rreg(8'd10, 8'h26, "R7");
        wreg(8'd11, 8'h02);

        // R8/R9 periodic without then with enable
        pulse(0);
        chk_irq(1'b0, "R9");
        rreg(8'd12, 8'h40, "R8");
        wreg(8'd11, 8'h42);
        pulse(0);
        chk_irq(1'b1, "R9");
        rreg(8'd12, 8'hC0, "R9");
        chk_irq(1'b0, "R11");
        rreg(8'd12, 8'h00, "R11");

        // R10 alarm with wildcard minutes
        wreg(8'd1, 8'h30);
        wreg(8'd3, 8'hC0);
        wreg(8'd5, 8'h07);
        wreg(8'd11, 8'h22);
        cur_sec = 8'h30; cur_min = 8'h45; cur_hour = 8'h07;
        pulse(2);
        chk_irq(1'b1, "R10");
        rreg(8'd12, 8'hB0, "R10");
        chk_irq(1'b0, "R11");
        cur_sec = 8'h31;
        pulse(2);
        chk_irq(1'b0, "R10");
        rreg(8'd12, 8'h10, "R10");

        // R9 update-end enable
        wreg(8'd11, 8'h12);
        pulse(2);
        chk_irq(1'b1, "R9");
        rreg(8'd12, 8'h90, "R9");

        // R11 event coinciding with the clearing read survives
        wreg(8'd11, 8'h02);
        wr(1'b0, 8'd12);
        rd(1'b1, 8'h00, "R11", 1'b1);
        rd(1'b1, 8'h40, "R11", 1'b0);
        rd(1'b1, 8'h00, "R11", 1'b0);

        @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d reads pending, expected 0", sb_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule